// File: doc/BRIEF.md
# Spread-Spectrum Packet Formatter

This block turns four stored sensor samples into a spread-spectrum chip stream. While in load mode it accepts 10-bit samples into four 16-bit words. When switched to serial mode it sends a 65-bit packet: a single one as the start marker, followed by the 64 stored data bits. The packet is differentially encoded, and each encoded bit is XORed with a selected 63-chip spreading code.

There are two 6-bit generators for maximal-length sequences. A third code is formed as the XOR of their outputs, and a pin can also supply an external code. The chip generators step on a chip enable. The packet bit advances on a separate bit enable, which the surrounding logic pulses once every 63 chips. Because both generators reload whenever the block is in load mode, every packet starts at the same code phase.

Top module: `ss_packet_fmt`

## Requirements
- R1: In load mode (`serial_mode`=0), a pulse on `wr_en` stores `wr_data` into the word chosen by `wr_addr`. Channel n goes to address n, for n from 0 to 3.
- R2: A write presented while `serial_mode`=1 leaves the stored words unchanged.
- R3: Each stored word holds the 10-bit sample in its low bits and zero in its upper 6 bits. Data is serialized starting with bit 0 of word 0, and bit 15 of word 3 is the 64th data bit.
- R4: Packet bit 0 is a preamble of logic one and is followed by 64 data bits. Once bit 64 has passed, further bit enables feed zero into the encoder.
- R5: `enc_bit` = prev XOR in(k), where prev is the encoded value of the previous packet bit. prev is cleared to 0 while in load mode.
- R6: Generator A has a 6-bit state s with output s[0]. Each step shifts in s[1]^s[0] at s[5]. This is the recurrence of 1+x+x^6, and the state is preset to all ones.
- R7: Generator B has output s[0]. Each step shifts in s[5]^s[2]^s[1]^s[0], the recurrence of 1+x+x^2+x^5+x^6. Its preset is all ones when `preset_sel`=0, and `b_preset` (bit i into s[i]) when `preset_sel`=1.
- R8: `code_sel` picks `code_out`: 0 selects A XOR B, 1 selects A, 2 selects B and 3 selects `ext_code`. `spread_out` = `enc_bit` XOR `code_out`.
- R9: The generators step only on `chip_en` in serial mode, and the packet bit advances only on `bit_en` in serial mode. Both generators reload their presets in every load-mode cycle, so each packet bit of 63 chips sees the code from phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | 2 | Word (channel) address |
| wr_data | input | 10 | Sample value |
| serial_mode | input | 1 | 0 = load, 1 = transmit packet |
| chip_en | input | 1 | Advances code generators by one chip |
| bit_en | input | 1 | Advances the packet by one bit |
| code_sel | input | 2 | Spreading code select |
| preset_sel | input | 1 | Generator B preset source |
| b_preset | input | 6 | External generator B preset |
| ext_code | input | 1 | External spreading code chip |
| code_out | output | 1 | Selected spreading code chip |
| enc_bit | output | 1 | Differentially encoded packet bit |
| spread_out | output | 1 | Spread output chip |

## Verification
Full packets are sent once with each of the four code selections. Because the outputs of the Gold, A-only and B-only packets differ, any exchange of the generator taps or of the select encoding becomes visible. One packet loads B from a nonzero external preset and one from all ones, which separates the two preset paths. One packet inserts idle cycles between chips to show that the state holds when `chip_en` is low. Sample values are chosen with distinct low and high bits so that a bit-order or word-order error changes the encoded stream. A write made in the middle of a packet, followed by bit enables after the packet has ended, covers the ignore and hold cases.

// File: rtl/ss_packet_fmt.sv
module ss_packet_fmt #(
  parameter int WORDS    = 4,
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 10,
  parameter int LFSR_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(WORDS)-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0]        wr_data,
  input  logic                       serial_mode,
  input  logic                       chip_en,
  input  logic                       bit_en,
  input  logic [1:0]                 code_sel,
  input  logic                       preset_sel,
  input  logic [LFSR_W-1:0]          b_preset,
  input  logic                       ext_code,
  output logic                       code_out,
  output logic                       enc_bit,
  output logic                       spread_out
);
  localparam int DATA_BITS = WORDS * WORD_W;
  localparam int PKT_BITS  = DATA_BITS + 1;
  localparam int IDX_W     = $clog2(PKT_BITS + 1);
  localparam int POS_W     = $clog2(DATA_BITS);

  logic [DATA_BITS-1:0] mem_flat;
  logic [IDX_W-1:0]     bit_idx;
  logic [IDX_W-1:0]     data_pos;
  logic                 enc_prev;
  logic                 pkt_in;
  logic [LFSR_W-1:0]    lfsr_a, lfsr_b, b_init;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mem_flat <= '0;
    else if (wr_en && !serial_mode)
      mem_flat[wr_addr*WORD_W +: WORD_W] <= {{(WORD_W-SAMPLE_W){1'b0}}, wr_data};

  assign data_pos = bit_idx - 1'b1;
  assign pkt_in   = (bit_idx == '0) ? 1'b1 :
                    (bit_idx <= IDX_W'(DATA_BITS)) ? mem_flat[data_pos[POS_W-1:0]] : 1'b0;
  assign enc_bit  = enc_prev ^ pkt_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_idx  <= '0;
      enc_prev <= 1'b0;
    end else if (!serial_mode) begin
      bit_idx  <= '0;
      enc_prev <= 1'b0;
    end else if (bit_en) begin
      enc_prev <= enc_bit;
      if (bit_idx != IDX_W'(PKT_BITS)) bit_idx <= bit_idx + 1'b1;
    end

  assign b_init = preset_sel ? b_preset : '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lfsr_a <= '1;
      lfsr_b <= '1;
    end else if (!serial_mode) begin
      lfsr_a <= '1;
      lfsr_b <= b_init;
    end else if (chip_en) begin
      lfsr_a <= {lfsr_a[1] ^ lfsr_a[0], lfsr_a[LFSR_W-1:1]};
      lfsr_b <= {lfsr_b[5] ^ lfsr_b[2] ^ lfsr_b[1] ^ lfsr_b[0], lfsr_b[LFSR_W-1:1]};
    end

  always_comb
    case (code_sel)
      2'd0:    code_out = lfsr_a[0] ^ lfsr_b[0];
      2'd1:    code_out = lfsr_a[0];
      2'd2:    code_out = lfsr_b[0];
      default: code_out = ext_code;
    endcase

  assign spread_out = enc_bit ^ code_out;

  a_r2_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode && wr_en) |=> $stable(mem_flat));
  a_r4_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_mode) |=> (!serial_mode || enc_bit));
  a_r5_prev_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode && !bit_en) |=> $stable(enc_prev));
  a_r6_a_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_a != '0);
  a_r7_b_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_mode && !preset_sel) |=> (lfsr_b == '1));
  a_r9_idx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode && !bit_en) |=> $stable(bit_idx));
endmodule

// File: tb/ss_packet_fmt_bench.sv
module ss_packet_fmt_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, serial_mode = 0, chip_en = 0, bit_en = 0;
  logic [1:0] wr_addr = 0, code_sel = 0;
  logic [9:0] wr_data = 0;
  logic preset_sel = 0, ext_code = 0;
  logic [5:0] b_preset = 0;
  logic code_out, enc_bit, spread_out;

  int compared = 0, mismatched = 0;
  logic [63:0] model_mem = '0;
  logic [2:0]  exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ss_packet_fmt u_ss_packet_fmt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .serial_mode(serial_mode), .chip_en(chip_en), .bit_en(bit_en), .code_sel(code_sel),
    .preset_sel(preset_sel), .b_preset(b_preset), .ext_code(ext_code),
    .code_out(code_out), .enc_bit(enc_bit), .spread_out(spread_out));

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {code,enc,spread} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_word(input int a, input logic [9:0] d);
    step();
    serial_mode = 0; wr_en = 1; wr_addr = 2'(a); wr_data = d;
    model_mem[a*16 +: 16] = {6'b0, d};
    step();
    wr_en = 0;
  endtask

  function automatic void gen_seq(input logic [5:0] init, input bit is_b, output logic s[63]);
    for (int i = 0; i < 6; i++) s[i] = init[i];
    for (int n = 0; n < 57; n++)
      s[n+6] = is_b ? (s[n+5] ^ s[n+2] ^ s[n+1] ^ s[n]) : (s[n+1] ^ s[n]);
  endfunction

  task automatic run_packet(input logic [1:0] cs, input logic ps, input logic [5:0] pv,
                            input bit gaps, input bit late_write, input string req);
    logic sa[63], sb[63];
    logic e, in_bit, c, x;
    gen_seq(6'h3f, 0, sa);
    gen_seq(ps ? pv : 6'h3f, 1, sb);
    step();
    serial_mode = 0; code_sel = cs; preset_sel = ps; b_preset = pv;
    step(); step();
    serial_mode = 1;
    e = 0;
    for (int k = 0; k < 68; k++) begin
      in_bit = (k == 0) ? 1'b1 : (k <= 64) ? model_mem[k-1] : 1'b0;
      e = e ^ in_bit;
      for (int j = 0; j < 63; j++) begin
        x = j[0] ^ k[1];
        case (cs)
          2'd0: c = sa[j] ^ sb[j];
          2'd1: c = sa[j];
          2'd2: c = sb[j];
          default: c = x;
        endcase
        exp_q.push_back({c, e, c ^ e});
        tag_q.push_back(k > 64 ? "R4" : (k == 2 && late_write) ? "R2" : req);
        chip_en = 1; bit_en = (j == 62); ext_code = x;
        wr_en = late_write && k == 1 && j == 0;
        wr_addr = 0; wr_data = 10'h2aa ^ model_mem[9:0];
        step();
        chip_en = 0; bit_en = 0; wr_en = 0;
        if (gaps) step();
      end
    end
    serial_mode = 0;
  endtask

  initial begin : monitor
    logic [2:0] exp;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && chip_en && exp_q.size() > 0) begin
        exp = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {code_out, enc_bit, spread_out}, exp);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    repeat (3) step();
    rst_n = 1;
    @(negedge clk);
    check("R5 reset", {code_out, enc_bit, spread_out}, 3'b011);
    // R1 R3: distinct low/high bits per channel
    write_word(0, 10'h301);
    write_word(1, 10'h0f2);
    write_word(2, 10'h255);
    write_word(3, 10'h18c);
    run_packet(2'd0, 1'b0, 6'h00, 0, 0, "R8_gold");
    run_packet(2'd1, 1'b0, 6'h00, 1, 0, "R6_R9");
    run_packet(2'd2, 1'b1, 6'h25, 0, 1, "R7");
    write_word(1, 10'h3c0);
    write_word(3, 10'h007);
    run_packet(2'd3, 1'b0, 6'h00, 0, 0, "R3_R8_ext");
    run_packet(2'd0, 1'b1, 6'h13, 0, 0, "R5_R7");
    repeat (4) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule